// File: doc/BRIEF.md
# UART Baud Divisor and Oversampling Tick Generator

This block holds the 13-bit divisor that sets a UART's bit rate. It produces a one-clock tick that repeats once every divisor cycles of the module clock. The tick runs at sixteen times the baud rate and feeds the transmitter and receiver shifters, which are outside this block.

Software writes the divisor over a narrow 8-bit register port in two bytes. The upper five bits are written first and held in a staging register. Nothing changes until the lower byte is written, and at that point all 13 bits take effect together. The divisor therefore never passes through a mix of an old half and a new half.

The generator does not run straight out of reset. It waits until the transmit enable or the receive enable has been raised once, and it then stays armed for good. A divisor of zero keeps it silent. A flag output reports an odd divisor while the narrow infrared pulse option is selected, because that option needs an even divisor.

Top module: `baud_div_gen`

## Requirements
- R1: After reset the active divisor is 4. A read at address 0 returns 0x00, a read at address 1 returns 0x04, and `tick` is low.
- R2: A write at address 0 (the upper byte) only loads the staging register. Both the address-0 readback and the tick period keep their previous values until the next address-1 write.
- R3: A write at address 1 sets the active divisor to {staging[4:0], wdata[7:0]} in the clock edge that samples the write. An address-1 read then returns the written byte and an address-0 read returns the staged bits.
- R4: An address-0 read returns zero in bits 7:5 and the active divisor's bits 12:8 in bits 4:0. Bits 7:5 of an address-0 write are discarded.
- R5: `tick` stays low from reset until `tx_en` or `rx_en` has been sampled high. From then on ticks continue even when both enables are low.
- R6: While the active divisor is zero, `tick` never goes high.
- R7: While running with divisor N ≥ 1, `tick` is high for one clock out of every N, so the rising edges of `tick` are exactly N cycles apart.
- R8: An address-1 write restarts the count. Counting the cycle straight after the committing edge as cycle 1, the first tick appears in cycle N.
- R9: `odd_div_err` is high exactly when `narrow_ir` is high and bit 0 of the active divisor is 1.
- R10: The staging register resets to zero and keeps its value across commits. An address-1 write with no address-0 write since reset gives an upper part of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 1 | Byte select for reads and writes: 0 upper, 1 lower |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational readback of the byte selected by `reg_addr` |
| tx_en | input | 1 | Transmit enable (arms the generator) |
| rx_en | input | 1 | Receive enable (arms the generator) |
| narrow_ir | input | 1 | Narrow infrared pulse option selected |
| tick | output | 1 | One-cycle oversampling tick |
| odd_div_err | output | 1 | Odd divisor while the narrow infrared option is selected |

## Verification
A corrupted active divisor is visible on the very next read, and it also changes the tick spacing within one period. A staging register that leaks through early shows up as a changed address-0 readback in the cycle after an upper-byte write. A counter that fails to restart on commit moves the first tick away from cycle N. A wrong arm flag either emits ticks before any enable or stops them once the enables drop, and both cases appear within one divisor period.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  // Byte select on the register port.
  typedef enum logic {
    SEL_HI = 1'b0,
    SEL_LO = 1'b1
  } bdg_sel_e;
endpackage

// File: rtl/bdg_regs.sv
module bdg_regs
  import bdg_pkg::*;
#(
  parameter int DIV_W   = 13,
  parameter int BUS_W   = 8,
  parameter int RST_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             addr,
  input  logic [BUS_W-1:0] wdata,
  output logic [DIV_W-1:0] div,
  output logic             commit,
  output logic [BUS_W-1:0] rdata
);
  localparam int HI_W  = DIV_W - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;

  logic [HI_W-1:0]  hold_q, hold_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             wr_hi, wr_lo;

  assign wr_hi  = wr && (bdg_sel_e'(addr) == SEL_HI);
  assign wr_lo  = wr && (bdg_sel_e'(addr) == SEL_LO);
  assign commit = wr_lo;

  always_comb begin
    hold_d = hold_q;
    div_d  = div_q;
    if (wr_hi) hold_d = wdata[HI_W-1:0];
    if (wr_lo) div_d  = {hold_q, wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      div_q  <= DIV_W'(RST_DIV);
    end else begin
      if (wr_hi) hold_q <= hold_d;
      if (wr_lo) div_q  <= div_d;
    end
  end

  assign div   = div_q;
  assign rdata = (bdg_sel_e'(addr) == SEL_LO) ? div_q[BUS_W-1:0]
                                              : {{PAD_W{1'b0}}, div_q[DIV_W-1:BUS_W]};
endmodule

// File: rtl/bdg_arm.sv
module bdg_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_en,
  input  logic rx_en,
  output logic armed
);
  logic armed_q, armed_d;

  always_comb armed_d = armed_q | tx_en | rx_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed_q <= 1'b0;
    else if (!armed_q) armed_q <= armed_d;
  end

  assign armed = armed_q;
endmodule

// File: rtl/bdg_tick.sv
module bdg_tick #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             run, last;

  assign run  = armed && (div != '0);
  assign last = (cnt_q == div - ONE);

  always_comb begin
    if (restart || !run || last) cnt_d = '0;
    else                         cnt_d = cnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && last;
endmodule

// File: rtl/baud_div_gen.sv
module baud_div_gen #(
  parameter int DIV_W   = 13,
  parameter int BUS_W   = 8,
  parameter int RST_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [BUS_W-1:0] reg_wdata,
  output logic [BUS_W-1:0] reg_rdata,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             narrow_ir,
  output logic             tick,
  output logic             odd_div_err
);
  logic [DIV_W-1:0] div_act;
  logic             commit;
  logic             armed;

  bdg_regs #(.DIV_W(DIV_W), .BUS_W(BUS_W), .RST_DIV(RST_DIV)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .div    (div_act),
    .commit (commit),
    .rdata  (reg_rdata)
  );

  bdg_arm u_arm (
    .clk   (clk),
    .rst_n (rst_n),
    .tx_en (tx_en),
    .rx_en (rx_en),
    .armed (armed)
  );

  bdg_tick #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (armed),
    .restart (commit),
    .div     (div_act),
    .tick    (tick)
  );

  assign odd_div_err = narrow_ir & div_act[0];
endmodule

// File: rtl/bdg_chk.sv
module bdg_chk #(
  parameter int DIV_W = 13,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic [BUS_W-1:0] reg_wdata,
  input logic [BUS_W-1:0] reg_rdata,
  input logic             tx_en,
  input logic             rx_en,
  input logic             tick,
  input logic [DIV_W-1:0] div_q
);
  localparam int HI_W = DIV_W - BUS_W;

  logic             seen_en;
  logic             prev_ok;
  logic [DIV_W:0]   gap;
  logic             wr_lo;

  assign wr_lo = reg_wr && reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_en <= 1'b0;
      prev_ok <= 1'b0;
      gap     <= '0;
    end else begin
      if (tx_en || rx_en) seen_en <= 1'b1;
      if (wr_lo || !seen_en || div_q == '0) prev_ok <= 1'b0;
      else if (tick)                         prev_ok <= 1'b1;
      gap <= tick ? (DIV_W+1)'(1) : gap + (DIV_W+1)'(1);
    end
  end

  // R5
  idle_before_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_en |-> !tick);

  // R6
  zero_div_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q == '0) |-> !tick);

  // R2
  staged_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_addr) |=> $stable(div_q));

  // R3
  commit_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (div_q[BUS_W-1:0] == $past(reg_wdata)));

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (!tick || div_q == DIV_W'(1)));

  // R7
  period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && prev_ok) |-> (gap == {1'b0, div_q}));

  // R4
  upper_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_addr |-> (reg_rdata[BUS_W-1:HI_W] == '0));
endmodule

bind baud_div_gen bdg_chk #(.DIV_W(DIV_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .tick      (tick),
  .div_q     (div_act)
);

// File: tb/tb_baud_div_gen.sv
module tb_baud_div_gen;
  logic       clk;
  logic       rst_n;
  logic       reg_wr;
  logic       reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       tx_en, rx_en, narrow_ir;
  logic       tick, odd_div_err;

  int n_chk = 0;
  int n_bad = 0;

  baud_div_gen dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_en(tx_en),
    .rx_en(rx_en), .narrow_ir(narrow_ir), .tick(tick), .odd_div_err(odd_div_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [7:0] hi;
    logic [7:0] lo;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VECS [NV] = '{
    '{hi: 8'h00, lo: 8'h01},
    '{hi: 8'h00, lo: 8'h07},
    '{hi: 8'h01, lo: 8'h00},
    '{hi: 8'hE0, lo: 8'h0A},
    '{hi: 8'h03, lo: 8'h02}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_byte(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic int rd_byte_now(input logic a);
    return 0;
  endfunction

  task automatic rd_byte(input logic a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  // Called at a negedge; first = index of the first negedge with tick high
  // (the current one is 1), per = distance to the next tick.
  task automatic measure(output int first, output int per);
    first = 1;
    while (!tick && first < 3000) begin @(negedge clk); first++; end
    per = 0;
    do begin @(negedge clk); per++; end while (!tick && per < 3000);
  endtask

  task automatic count_ticks(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tick) seen++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, f, p, s;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
    tx_en = 1'b0; rx_en = 1'b0; narrow_ir = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_byte(1'b0, v); check("R1 hi", v, 0);
    rd_byte(1'b1, v); check("R1 lo", v, 4);
    check("R1 tick", int'(tick), 0);

    // R5 no ticks before any enable
    count_ticks(40, s); check("R5 idle", s, 0);

    // R5 arm with a one-cycle rx_en pulse, then both low: still ticks
    rx_en = 1'b1; @(negedge clk); rx_en = 1'b0;
    measure(f, p); check("R5 sticky R7 period", p, 4);
    count_ticks(40, s); check("R7 count in 40", s, 10);

    // R10 commit without an upper write: upper part is zero
    wr_byte(1'b1, 8'h09);
    rd_byte(1'b0, v); check("R10 hi", v, 0);
    measure(f, p);
    check("R8 first", f, 9); check("R10 period", p, 9);

    // Table of divisor writes
    for (int i = 0; i < NV; i++) begin
      int exp_div;
      exp_div = {19'd0, VECS[i].hi[4:0], VECS[i].lo};
      wr_byte(1'b0, VECS[i].hi);
      wr_byte(1'b1, VECS[i].lo);
      measure(f, p);
      check("R8 first tick", f, exp_div);
      check("R7 period", p, exp_div);
      rd_byte(1'b0, v); check("R4 R3 hi readback", v, int'(VECS[i].hi[4:0]));
      rd_byte(1'b1, v); check("R3 lo readback", v, int'(VECS[i].lo));
    end

    // R2 upper write alone changes nothing visible (divisor 770 now)
    wr_byte(1'b1, 8'h0A);            // staging still 3 -> 0x30A = 778
    wr_byte(1'b0, 8'h00);            // stage 0
    wr_byte(1'b1, 8'h0A);            // divisor 10
    wr_byte(1'b0, 8'h02);            // stage 2 only
    rd_byte(1'b0, v); check("R2 hi unchanged", v, 0);
    rd_byte(1'b1, v); check("R2 lo unchanged", v, 10);
    measure(f, p); check("R2 period unchanged", p, 10);
    wr_byte(1'b1, 8'h05);
    rd_byte(1'b0, v); check("R3 staged hi applied", v, 2);

    // R10 staging keeps its value across commits
    wr_byte(1'b1, 8'h00);
    rd_byte(1'b0, v); check("R10 staging kept", v, 2);

    // R8 commit in the middle of a period restarts the count
    wr_byte(1'b0, 8'h00);
    wr_byte(1'b1, 8'h0C);
    measure(f, p);
    repeat (5) @(negedge clk);
    wr_byte(1'b1, 8'h0C);
    measure(f, p); check("R8 mid-period restart", f, 12);

    // R6 zero divisor is silent
    wr_byte(1'b1, 8'h00);
    count_ticks(300, s); check("R6 zero silent", s, 0);

    // R9 odd flag
    wr_byte(1'b1, 8'h03);
    check("R9 odd off", int'(odd_div_err), 0);
    narrow_ir = 1'b1; #1;
    check("R9 odd on", int'(odd_div_err), 1);
    wr_byte(1'b1, 8'h04);
    check("R9 even", int'(odd_div_err), 0);
    measure(f, p); check("R7 period after narrow", p, 4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule